// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style processor, joined to that processor's 8-bit status register. Each cycle it takes an operation code, the accumulator value, an operand and the stored flags. It returns the operation's result combinationally. When `valid_i` is high it also commits the new flags on the rising clock edge. For each operation it decides which flags change and which stay as they were.

The status register sets C, Z, I, D, V and N, and two bit positions are fixed at 1. Software can overwrite it from a byte popped off the stack. The push path reads `flags_o` directly. The decimal flag is stored but has no effect: addition and subtraction are always binary. Carry after a subtraction or compare means "no borrow". Instruction decode, memory access and register file updates belong to the surrounding core. For example, the core decides whether `result_o` is written back to a register.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `flags_o` reads 0x34: I set, bits 5 and 4 set, all other flags clear.
- R2: Status bit positions are C=0, Z=1, I=2, D=3, V=6, N=7. Bits 5 and 4 always read 1 and ignore any written value.
- R3: Add with carry (op 0): result = (a + m + C) mod 256. C takes the carry out. V is set when a and m share a sign and the result's sign differs. N and Z follow the result. A set D flag does not change the binary result.
- R4: Subtract with borrow (op 1): result = (a - m - (1 - C)) mod 256. C is set when no borrow occurs. V uses the add rule with m inverted. N and Z follow the result.
- R5: Compare (op 2): result = (a - m) mod 256, ignoring C. C = (a >= m), Z = (a == m), N = result bit 7. V, D and I are unchanged.
- R6: AND (op 3), OR (op 4) and XOR (op 5) of a and m change only N and Z.
- R7: Shifts act on m and change N, Z and C. Shift left (op 6) and logical shift right (op 7) move the shifted-out bit into C and shift in 0, so the right shift always clears N. Rotate left (op 8) and rotate right (op 9) are 9-bit rotations through C.
- R8: Bit test (op 10): N = m bit 7, V = m bit 6, Z = ((a & m) == 0). C, D and I are unchanged, and result = a.
- R9: Increment (op 11) and decrement (op 12) act on m, wrap modulo 256, and change only N and Z.
- R10: Load (op 13) returns m and changes only N and Z. Pass (op 14), used for stores and stack-pointer transfers, returns m and changes no flag. Codes 23 to 31 behave as pass.
- R11: Status pull (op 15) returns m and overwrites every flag with m, with bits 5 and 4 forced to 1.
- R12: Flag ops change exactly one flag and return a: clear C (16), set C (17), clear I (18), set I (19), clear D (20), set D (21), clear V (22).
- R13: `result_o` follows the inputs in the same cycle. `flags_o` changes only at a rising edge where `valid_i` is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit the flag update of this cycle's operation |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator (or compared register) value |
| m_i | input | 8 | Operand; also the byte pulled into the status register |
| result_o | output | 8 | Combinational result |
| flags_o | output | 8 | Status register contents, for flag use and for pushing |

## Verification
`result_o` is due in the cycle its inputs are applied. The bench drives inputs on a falling edge and samples the result 2 ns later, well before the next rising edge. `flags_o` is due one rising edge after the operation is presented with `valid_i` high, so the bench samples it 1 ns after that edge and then drops `valid_i`. The combinational sweeps over every accumulator/operand pair keep `valid_i` low and change the inputs every 2 ns. There the flags must not move at the rising edges that fall inside the sweep.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned OP_W = 5;
  localparam int unsigned ST_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ADC  = 5'd0,  OP_SBC  = 5'd1,  OP_CMP  = 5'd2,
    OP_AND  = 5'd3,  OP_OR   = 5'd4,  OP_XOR  = 5'd5,
    OP_ASL  = 5'd6,  OP_LSR  = 5'd7,  OP_ROL  = 5'd8,
    OP_ROR  = 5'd9,  OP_BIT  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_LOAD = 5'd13, OP_PASS = 5'd14,
    OP_PULL = 5'd15, OP_CLC  = 5'd16, OP_SEC  = 5'd17,
    OP_CLI  = 5'd18, OP_SEI  = 5'd19, OP_CLD  = 5'd20,
    OP_SED  = 5'd21, OP_CLV  = 5'd22
  } alu_op_e;

  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_I = 2;
  localparam int unsigned FLG_D = 3;
  localparam int unsigned FLG_V = 6;
  localparam int unsigned FLG_N = 7;

  localparam logic [ST_W-1:0] ST_FIXED = 8'h30;
  localparam logic [ST_W-1:0] ST_RESET = 8'h34;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              carry_i,
  input  logic              sub_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] m_eff;
  logic              cin;
  logic [DATA_W:0]   full;

  assign m_eff = sub_i ? ~m_i : m_i;
  // compare ignores the stored carry: plain a - m
  assign cin   = cmp_i ? 1'b1 : carry_i;
  assign full  = {1'b0, a_i} + {1'b0, m_eff} + {{DATA_W{1'b0}}, cin};

  assign sum_o   = full[DATA_W-1:0];
  assign carry_o = full[DATA_W];
  assign ovf_o   = (a_i[MSB] == m_eff[MSB]) && (full[MSB] != a_i[MSB]);

  always_comb begin
    if (cmp_i && sub_i) begin
      a_r5_cmp_carry: assert (carry_o == (a_i >= m_i));
    end
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops import acc_alu_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    res_o   = m_i;
    carry_o = carry_i;
    case (op_i)
      OP_AND:         res_o = a_i & m_i;
      OP_BIT:         res_o = a_i & m_i;
      OP_OR:          res_o = a_i | m_i;
      OP_XOR:         res_o = a_i ^ m_i;
      OP_ASL:         {carry_o, res_o} = {m_i, 1'b0};
      OP_LSR:         {res_o, carry_o} = {1'b0, m_i};
      OP_ROL:         {carry_o, res_o} = {m_i, carry_i};
      OP_ROR:         {res_o, carry_o} = {carry_i, m_i};
      OP_INC:         res_o = m_i + ONE;
      OP_DEC:         res_o = m_i - ONE;
      default:        res_o = m_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status import acc_alu_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [ST_W-1:0] d_i,
  output logic [ST_W-1:0] q_o
);
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= ST_RESET;
    else if (load_i) st_q <= d_i | ST_FIXED;
  end

  assign q_o = st_q;

  a_r13_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  a_r2_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o[5:4] == 2'b11);
endmodule

// File: rtl/acc_alu.sv
module acc_alu import acc_alu_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  output logic [DATA_W-1:0] result_o,
  output logic [ST_W-1:0]   flags_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [ST_W-1:0]   st_q, st_d;
  logic [DATA_W-1:0] sum, lg_res, res;
  logic              sum_c, sum_v, lg_c;
  logic              is_sub, is_cmp;
  logic              wr_nz, wr_c, wr_v;
  logic              c_n, v_n, n_n, z_n;

  assign is_cmp = (op_i == OP_CMP);
  assign is_sub = (op_i == OP_SBC) || is_cmp;

  acc_alu_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i     (a_i),
    .m_i     (m_i),
    .carry_i (st_q[FLG_C]),
    .sub_i   (is_sub),
    .cmp_i   (is_cmp),
    .sum_o   (sum),
    .carry_o (sum_c),
    .ovf_o   (sum_v)
  );

  acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i    (op_i),
    .a_i     (a_i),
    .m_i     (m_i),
    .carry_i (st_q[FLG_C]),
    .res_o   (lg_res),
    .carry_o (lg_c)
  );

  always_comb begin
    res   = m_i;
    st_d  = st_q;
    wr_nz = 1'b0;
    wr_c  = 1'b0;
    wr_v  = 1'b0;
    c_n   = st_q[FLG_C];
    v_n   = st_q[FLG_V];
    case (op_i)
      OP_ADC, OP_SBC: begin
        res = sum; wr_nz = 1'b1; wr_c = 1'b1; wr_v = 1'b1;
        c_n = sum_c; v_n = sum_v;
      end
      OP_CMP: begin
        res = sum; wr_nz = 1'b1; wr_c = 1'b1; c_n = sum_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_LOAD: begin
        res = lg_res; wr_nz = 1'b1;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res = lg_res; wr_nz = 1'b1; wr_c = 1'b1; c_n = lg_c;
      end
      OP_BIT: begin
        res = a_i; wr_nz = 1'b1; wr_v = 1'b1; v_n = m_i[MSB-1];
      end
      OP_PULL: begin
        res = m_i; st_d = m_i[ST_W-1:0];
      end
      OP_CLC: begin res = a_i; st_d[FLG_C] = 1'b0; end
      OP_SEC: begin res = a_i; st_d[FLG_C] = 1'b1; end
      OP_CLI: begin res = a_i; st_d[FLG_I] = 1'b0; end
      OP_SEI: begin res = a_i; st_d[FLG_I] = 1'b1; end
      OP_CLD: begin res = a_i; st_d[FLG_D] = 1'b0; end
      OP_SED: begin res = a_i; st_d[FLG_D] = 1'b1; end
      OP_CLV: begin res = a_i; st_d[FLG_V] = 1'b0; end
      default: res = m_i;
    endcase
    // bit test takes N from the operand and Z from the masked value
    n_n = (op_i == OP_BIT) ? m_i[MSB] : res[MSB];
    z_n = (op_i == OP_BIT) ? (lg_res == ZERO) : (res == ZERO);
    if (wr_nz) begin
      st_d[FLG_N] = n_n;
      st_d[FLG_Z] = z_n;
    end
    if (wr_c) st_d[FLG_C] = c_n;
    if (wr_v) st_d[FLG_V] = v_n;
  end

  acc_alu_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .d_i    (st_d),
    .q_o    (st_q)
  );

  assign result_o = res;
  assign flags_o  = st_q;

  a_r10_pass_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_PASS |=> flags_o == $past(flags_o));
  a_r6_logic_nz_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
    |=> (flags_o & 8'h4D) == ($past(flags_o) & 8'h4D));
  a_r7_lsr_clears_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_LSR |=> !flags_o[FLG_N]);
  a_r11_pull_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_PULL |=> flags_o == ($past(m_i[ST_W-1:0]) | ST_FIXED));
  a_r8_bit_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_BIT
    |=> flags_o[FLG_N] == $past(m_i[MSB]) && flags_o[FLG_V] == $past(m_i[MSB-1]));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [4:0] op = 5'd14;
  logic [7:0] a = 8'h00;
  logic [7:0] m = 8'h00;
  logic [7:0] result;
  logic [7:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] st_m = 8'h34;

  always #5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid),
    .op_i     (op),
    .a_i      (a),
    .m_i      (m),
    .result_o (result),
    .flags_o  (flags)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] o);
    case (o)
      5'd0: return "R3";
      5'd1: return "R4";
      5'd2: return "R5";
      5'd3, 5'd4, 5'd5: return "R6";
      5'd6, 5'd7, 5'd8, 5'd9: return "R7";
      5'd10: return "R8";
      5'd11, 5'd12: return "R9";
      5'd15: return "R11";
      default: return (o >= 5'd16 && o <= 5'd22) ? "R12" : "R10";
    endcase
  endfunction

  // returns {result, new status}
  function automatic logic [15:0] model(input logic [4:0] o, input logic [7:0] av, input logic [7:0] mv, input logic [7:0] st);
    logic [7:0] r, s;
    int c, u, sv;
    logic nz;
    s = st; r = mv; nz = 1'b0;
    c = int'(st[0]);
    case (o)
      5'd0: begin
        u = int'(av) + int'(mv) + c;
        sv = int'($signed(av)) + int'($signed(mv)) + c;
        r = 8'(u); s[0] = (u > 255); s[6] = (sv > 127 || sv < -128); nz = 1'b1;
      end
      5'd1: begin
        u = int'(av) - int'(mv) - (1 - c);
        sv = int'($signed(av)) - int'($signed(mv)) - (1 - c);
        r = 8'(u); s[0] = (u >= 0); s[6] = (sv > 127 || sv < -128); nz = 1'b1;
      end
      5'd2: begin r = av - mv; s[0] = (av >= mv); nz = 1'b1; end
      5'd3: begin r = av & mv; nz = 1'b1; end
      5'd4: begin r = av | mv; nz = 1'b1; end
      5'd5: begin r = av ^ mv; nz = 1'b1; end
      5'd6: begin r = mv * 2; s[0] = mv[7]; nz = 1'b1; end
      5'd7: begin r = mv / 2; s[0] = mv[0]; nz = 1'b1; end
      5'd8: begin r = 8'(mv * 2 + c); s[0] = mv[7]; nz = 1'b1; end
      5'd9: begin r = 8'(mv / 2 + c * 128); s[0] = mv[0]; nz = 1'b1; end
      5'd10: begin
        r = av; s[7] = mv[7]; s[6] = mv[6]; s[1] = ((av & mv) == 8'h00);
      end
      5'd11: begin r = mv + 8'd1; nz = 1'b1; end
      5'd12: begin r = mv - 8'd1; nz = 1'b1; end
      5'd13: begin r = mv; nz = 1'b1; end
      5'd15: begin r = mv; s = mv | 8'h30; end
      5'd16: begin r = av; s[0] = 1'b0; end
      5'd17: begin r = av; s[0] = 1'b1; end
      5'd18: begin r = av; s[2] = 1'b0; end
      5'd19: begin r = av; s[2] = 1'b1; end
      5'd20: begin r = av; s[3] = 1'b0; end
      5'd21: begin r = av; s[3] = 1'b1; end
      5'd22: begin r = av; s[6] = 1'b0; end
      default: r = mv;
    endcase
    if (nz) begin s[7] = r[7]; s[1] = (r == 8'h00); end
    return {r, s};
  endfunction

  task automatic run_op(input logic [4:0] o, input logic [7:0] av, input logic [7:0] mv);
    logic [15:0] e;
    e = model(o, av, mv, st_m);
    @(negedge clk);
    op = o; a = av; m = mv; valid = 1'b1;
    #2 chk(req_of(o), "result", result, e[15:8]);
    @(posedge clk);
    #1 valid = 1'b0;
    chk(req_of(o), "flags", flags, e[7:0]);
    st_m = e[7:0];
  endtask

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h40; 3: return 8'h7F;
      4: return 8'h80; 5: return 8'h81; 6: return 8'hC3; default: return 8'hFF;
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] e;
    #12 chk("R1", "flags in reset", flags, 8'h34);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R1", "flags after reset", flags, 8'h34);

    // directed corners
    run_op(5'd15, 8'h00, 8'h00);
    chk("R2", "pull zero keeps bits 5:4", flags, 8'h30);
    run_op(5'd15, 8'h00, 8'hFF);
    chk("R2", "pull all ones", flags, 8'hFF);
    run_op(5'd16, 8'h00, 8'h00);
    run_op(5'd0, 8'h7F, 8'h01);
    chk("R3", "signed overflow sets V,N", flags & 8'hC3, 8'hC0);
    run_op(5'd21, 8'h00, 8'h00);
    run_op(5'd16, 8'h00, 8'h00);
    run_op(5'd0, 8'h09, 8'h01);
    chk("R3", "decimal flag ignored", result, 8'h0A);
    run_op(5'd17, 8'h00, 8'h00);
    run_op(5'd1, 8'h00, 8'h01);
    chk("R4", "borrow clears C", flags[0] ? 8'h01 : 8'h00, 8'h00);
    run_op(5'd2, 8'h55, 8'h55);
    chk("R5", "equal compare sets Z and C", flags & 8'h03, 8'h03);
    run_op(5'd7, 8'h00, 8'hFF);
    chk("R7", "LSR clears N", flags & 8'h80, 8'h00);

    // R13: idle cycle keeps flags, result still combinational
    @(negedge clk);
    op = 5'd17; a = 8'h3C; m = 8'h00; valid = 1'b0;
    #2 chk("R13", "result without valid", result, 8'h3C);
    @(posedge clk); #1 chk("R13", "flags held without valid", flags, st_m);

    // sweep every op over operand pairs and varied starting flags
    for (int o = 0; o < 32; o++) begin
      for (int ai = 0; ai < 8; ai++) begin
        for (int mi = 0; mi < 8; mi++) begin
          run_op(5'd15, 8'h00, 8'(ai * 29 + mi * 53 + o * 7));
          run_op(5'(o), pick(ai), pick(mi));
        end
      end
    end

    // exhaustive combinational result sweep with valid low
    for (int k = 0; k < 5; k++) begin
      logic [4:0] so;
      so = (k < 2) ? 5'd0 : ((k < 4) ? 5'd1 : 5'd2);
      run_op(5'd15, 8'h00, (k % 2 == 1) ? 8'h01 : 8'h00);
      @(negedge clk);
      valid = 1'b0; op = so;
      for (int av = 0; av < 256; av++) begin
        for (int mv = 0; mv < 256; mv++) begin
          a = 8'(av); m = 8'(mv);
          #1;
          e = model(so, 8'(av), 8'(mv), st_m);
          chk(req_of(so), "sweep result", result, e[15:8]);
          #1;
        end
      end
      @(negedge clk);
      chk("R13", "flags unchanged after sweep", flags, st_m);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule